// File: doc/BRIEF.md
# Serial Packet Port Transmitter

This block sends one packet at a time into the serial input of a single router port. The host presents a destination address, a payload byte count and up to `MAX_BYTES` payload bytes. It raises `start` while `ready` is high. The block captures all of these values in that cycle and then serialises the packet on three wires, one bit per rising clock edge. Those wires are a data line, an active-low frame line and an active-low valid line.

A packet has three parts, in this order. First come the destination address bits. Then a fixed run of padding cycles. Then the payload bytes. The frame line falls with the first address bit and stays low until the final payload bit. On the final payload bit the frame line is high, and that is how a receiver finds the end of a variable-length packet. The valid line is low only on payload bits. After reset the block holds off for a fixed quiet period before it accepts any packet. A build option inserts a one-cycle invalid gap between payload bytes.

Top module: `pkt_serial_tx`

## Requirements
- R1: While `rst_n` is low, `ready` is 0. After `rst_n` rises, `ready` first reads 1 after the 17th rising edge: 2 edges of reset synchronisation, then a 15-cycle quiet period. A `start` before that has no effect.
- R2: When no packet is in progress, the outputs rest at these levels: `ser_data`=0, `ser_frame_n`=1 and `ser_valid_n`=1.
- R3: An edge with `ready`=1, `start`=1 and `pkt_len`≠0 accepts a packet, and the first packet bit appears in the next cycle. `ready` stays 0 up to and including the final-bit cycle and returns to 1 in the cycle after it. If `start` is held high, the next packet is accepted at once.
- R4: The packet begins with the `ADDR_W` bits of `dest_addr`, least significant bit first, with `ser_frame_n`=0 and `ser_valid_n`=1.
- R5: After the address come `PAD_CYCLES` cycles (5 by default) with `ser_data`=0, `ser_frame_n`=0 and `ser_valid_n`=1.
- R6: Payload byte k is `pkt_data[8k+7:8k]`. Bytes go out from k=0 upward, each least significant bit first, with `ser_valid_n`=0. A packet of n bytes without gaps lasts 4+5+8n cycles.
- R7: `ser_frame_n` is 0 on every packet bit except the final payload bit, where it is 1. The cycle after that bit is idle.
- R8: A `start` with `pkt_len`=0 is ignored: `ready` stays 1 and the outputs stay idle.
- R9: A `pkt_len` above `MAX_BYTES` sends exactly `MAX_BYTES` bytes.
- R10: With `BYTE_GAP`≠0, one cycle with `ser_data`=0, `ser_frame_n`=0 and `ser_valid_n`=1 sits between consecutive payload bytes. There is none after the last byte, so n bytes last 4+5+9n-1 cycles.
- R11: `dest_addr`, `pkt_len` and `pkt_data` are sampled only on the accepting edge. Changing them during a packet has no effect on it.
- R12: Driving `rst_n` low during a packet returns the outputs to idle and `ready` to 0 at once, and restarts the quiet period of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to send; taken only when `ready` is 1 |
| ready | output | 1 | Block is idle, its quiet period is over and it can accept `start` |
| dest_addr | input | ADDR_W | Destination port number |
| pkt_len | input | clog2(MAX_BYTES+1) | Payload byte count |
| pkt_data | input | 8*MAX_BYTES | Payload bytes, byte 0 in the low bits |
| ser_data | output | 1 | Serial data bit |
| ser_frame_n | output | 1 | Active-low frame; high on the final bit |
| ser_valid_n | output | 1 | Active-low payload-bit qualifier |

## Verification
The bench builds two copies side by side. Both use the default sizes (4 address bits, 8 bytes, 5 padding cycles, 15 quiet cycles). One copy has `BYTE_GAP`=0 and the other has `BYTE_GAP`=1, so the same stimulus exercises both the gapless payload timing and the inter-byte invalid cycles. An 8-byte buffer with a 4-bit length field allows counts of 9 to 15, which exercises the clamp to the buffer depth. A 15-cycle quiet period keeps the post-reset lockout and a mid-packet reset within a short run. Holding `start` high exercises the back-to-back case where a packet is accepted in the first cycle `ready` returns.

// File: rtl/pst_pkg.sv
package pst_pkg;

  localparam int BYTE_BITS = 8;
  localparam int BIT_W     = 3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_PAD  = 3'd2,
    PH_DATA = 3'd3,
    PH_GAP  = 3'd4
  } phase_e;

  // Index width for a range of n values, never below one bit.
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pst_rst_sync.sv
module pst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n_i) begin
        if (!rst_n_i) sync_q <= '0;
        else          sync_q <= 1'b1;
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/pst_quiet_timer.sv
module pst_quiet_timer #(
  parameter int QUIET_CYCLES = 15
) (
  input  logic clk,
  input  logic rst_n,
  output logic quiet_done
);

  localparam int QW = pst_pkg::idx_w(QUIET_CYCLES + 1);
  localparam logic [QW-1:0] Q_END = QW'(QUIET_CYCLES);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign quiet_done = (cnt_q == Q_END);
  assign cnt_en     = !quiet_done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + QW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pst_payload_buf.sv
module pst_payload_buf #(
  parameter int MAX_BYTES = 8,
  localparam int BSEL_W = pst_pkg::idx_w(MAX_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [MAX_BYTES*8-1:0]        din,
  input  logic [BSEL_W-1:0]             byte_sel,
  input  logic [pst_pkg::BIT_W-1:0]     bit_sel,
  output logic                          bit_o
);

  logic [MAX_BYTES-1:0][7:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    if (load) mem_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else        mem_q <= mem_d;
  end

  assign bit_o = mem_q[byte_sel][bit_sel];

endmodule

// File: rtl/pst_sequencer.sv
module pst_sequencer
  import pst_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int PAD_CYCLES = 5,
  parameter int MAX_BYTES  = 8,
  parameter int BYTE_GAP   = 0,
  localparam int LEN_W  = $clog2(MAX_BYTES + 1),
  localparam int BSEL_W = idx_w(MAX_BYTES),
  localparam int CNT_W  = idx_w(max3(ADDR_W, PAD_CYCLES, BYTE_BITS))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet_done,
  input  logic              start,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              payload_bit,
  output logic              buf_load,
  output logic [BSEL_W-1:0] byte_sel,
  output logic [BIT_W-1:0]  bit_sel,
  output logic              ready,
  output logic              ser_data,
  output logic              ser_frame_n,
  output logic              ser_valid_n
);

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_CYCLES - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BYTE_BITS - 1);
  localparam logic [LEN_W-1:0] LEN_MAX   = LEN_W'(MAX_BYTES);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BSEL_W-1:0] byte_q, byte_d;
  logic [BSEL_W-1:0] last_q, last_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  logic              gap_en;
  logic              accept;
  logic              bit_end;
  logic              final_byte;
  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  len_m1;

  generate
    if (BYTE_GAP != 0) begin : g_gap
      assign gap_en = 1'b1;
    end else begin : g_nogap
      assign gap_en = 1'b0;
    end
  endgenerate

  // Clamp the requested count to the buffer depth; index of the last byte.
  assign len_eff = (pkt_len > LEN_MAX) ? LEN_MAX : pkt_len;
  assign len_m1  = len_eff - LEN_W'(1);

  assign ready      = quiet_done && (ph_q == PH_IDLE);
  assign accept     = ready && start && (pkt_len != '0);
  assign bit_end    = (cnt_q == BIT_LAST);
  assign final_byte = (byte_q == last_q);
  assign buf_load   = accept;
  assign byte_sel   = byte_q;
  assign bit_sel    = cnt_q[BIT_W-1:0];

  // Next-state process
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    last_d = last_q;
    addr_d = addr_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d   = PH_ADDR;
          cnt_d  = '0;
          byte_d = '0;
          addr_d = dest_addr;
          last_d = len_m1[BSEL_W-1:0];
        end
      end
      PH_ADDR: begin
        addr_d = addr_q >> 1;
        if (cnt_q == ADDR_LAST) begin
          ph_d  = PH_PAD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_PAD: begin
        if (cnt_q == PAD_LAST) begin
          ph_d  = PH_DATA;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_DATA: begin
        if (bit_end) begin
          cnt_d = '0;
          if (final_byte) begin
            ph_d = PH_IDLE;
          end else if (gap_en) begin
            ph_d = PH_GAP;
          end else begin
            byte_d = byte_q + BSEL_W'(1);
          end
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_GAP: begin
        ph_d   = PH_DATA;
        cnt_d  = '0;
        byte_d = byte_q + BSEL_W'(1);
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      byte_q <= '0;
      last_q <= '0;
      addr_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
      last_q <= last_d;
      addr_q <= addr_d;
    end
  end

  // Wire levels decoded from registered state only.
  always_comb begin
    ser_data    = 1'b0;
    ser_frame_n = 1'b1;
    ser_valid_n = 1'b1;
    unique case (ph_q)
      PH_ADDR: begin
        ser_data    = addr_q[0];
        ser_frame_n = 1'b0;
      end
      PH_PAD, PH_GAP: begin
        ser_frame_n = 1'b0;
      end
      PH_DATA: begin
        ser_data    = payload_bit;
        ser_frame_n = bit_end && final_byte;
        ser_valid_n = 1'b0;
      end
      default: begin
        ser_data    = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/pkt_serial_tx.sv
module pkt_serial_tx #(
  parameter int ADDR_W       = 4,
  parameter int MAX_BYTES    = 8,
  parameter int PAD_CYCLES   = 5,
  parameter int QUIET_CYCLES = 15,
  parameter int SYNC_STAGES  = 2,
  parameter int BYTE_GAP     = 0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  output logic                             ready,
  input  logic [ADDR_W-1:0]                dest_addr,
  input  logic [$clog2(MAX_BYTES+1)-1:0]   pkt_len,
  input  logic [MAX_BYTES*8-1:0]           pkt_data,
  output logic                             ser_data,
  output logic                             ser_frame_n,
  output logic                             ser_valid_n
);

  localparam int BSEL_W = pst_pkg::idx_w(MAX_BYTES);

  logic                      rst_n_sync;
  logic                      quiet_done;
  logic                      buf_load;
  logic                      payload_bit;
  logic [BSEL_W-1:0]         byte_sel;
  logic [pst_pkg::BIT_W-1:0] bit_sel;

  pst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  pst_quiet_timer #(.QUIET_CYCLES(QUIET_CYCLES)) u_quiet (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .quiet_done (quiet_done)
  );

  pst_payload_buf #(.MAX_BYTES(MAX_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (buf_load),
    .din      (pkt_data),
    .byte_sel (byte_sel),
    .bit_sel  (bit_sel),
    .bit_o    (payload_bit)
  );

  pst_sequencer #(
    .ADDR_W     (ADDR_W),
    .PAD_CYCLES (PAD_CYCLES),
    .MAX_BYTES  (MAX_BYTES),
    .BYTE_GAP   (BYTE_GAP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .quiet_done  (quiet_done),
    .start       (start),
    .dest_addr   (dest_addr),
    .pkt_len     (pkt_len),
    .payload_bit (payload_bit),
    .buf_load    (buf_load),
    .byte_sel    (byte_sel),
    .bit_sel     (bit_sel),
    .ready       (ready),
    .ser_data    (ser_data),
    .ser_frame_n (ser_frame_n),
    .ser_valid_n (ser_valid_n)
  );

endmodule

// File: rtl/pst_tx_checker.sv
module pst_tx_checker #(
  parameter int LOCKOUT = 17,
  parameter int LEN_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] pkt_len,
  input logic             ready,
  input logic             ser_data,
  input logic             ser_frame_n,
  input logic             ser_valid_n
);

  int unsigned cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cyc_q <= 0;
    else if (cyc_q < LOCKOUT)         cyc_q <= cyc_q + 1;
  end

  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cyc_q >= LOCKOUT)); // R1

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ser_frame_n && ser_valid_n && !ser_data)); // R2

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && pkt_len != '0) |=> (!ready && !ser_frame_n && ser_valid_n)); // R3

  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_frame_n |=> !ready); // R3

  AST_FINAL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_frame_n && !ser_valid_n) |=> (ready && ser_frame_n && ser_valid_n)); // R7

  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && pkt_len == '0) |=> ready); // R8

endmodule

bind pkt_serial_tx pst_tx_checker #(
  .LOCKOUT (SYNC_STAGES + QUIET_CYCLES),
  .LEN_W   ($clog2(MAX_BYTES + 1))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .pkt_len     (pkt_len),
  .ready       (ready),
  .ser_data    (ser_data),
  .ser_frame_n (ser_frame_n),
  .ser_valid_n (ser_valid_n)
);

// File: tb/pkt_serial_tx_tb.sv
module pkt_serial_tx_tb;

  localparam int MAXB = 8;
  localparam int LOCK = 17;   // 2 sync edges + 15 quiet cycles

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  dest;
  logic [3:0]  plen;
  logic [63:0] pdata;
  logic [1:0]  rdy, sd, sf, sv;

  always #4 clk = ~clk;   // 125 MHz

  pkt_serial_tx #(.BYTE_GAP(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(rdy[0]),
    .dest_addr(dest), .pkt_len(plen), .pkt_data(pdata),
    .ser_data(sd[0]), .ser_frame_n(sf[0]), .ser_valid_n(sv[0]));

  pkt_serial_tx #(.BYTE_GAP(1)) u_dut_gap (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(rdy[1]),
    .dest_addr(dest), .pkt_len(plen), .pkt_data(pdata),
    .ser_data(sd[1]), .ser_frame_n(sf[1]), .ser_valid_n(sv[1]));

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  // Entry: [7:3] requirement tag, [2] data, [1] frame_n, [0] valid_n.
  logic [7:0] q0[$];
  logic [7:0] q1[$];
  logic [7:0] pk[$];
  int         since;

  task automatic build(input bit gap, input logic [3:0] a,
                       input logic [3:0] n_req, input logic [63:0] p);
    int n;
    logic [7:0] e;
    n = (n_req > MAXB) ? MAXB : int'(n_req);        // R9 clamp
    pk.delete();
    for (int k = 0; k < 4; k++) pk.push_back({5'd4, a[k], 2'b01});   // R4
    for (int k = 0; k < 5; k++) pk.push_back({5'd5, 3'b001});        // R5
    for (int b = 0; b < n; b++) begin
      for (int k = 0; k < 8; k++) pk.push_back({5'd6, p[8*b+k], 2'b00}); // R6
      if (gap && b != n - 1) pk.push_back({5'd10, 3'b001});          // R10
    end
    e = pk[pk.size()-1];
    pk[pk.size()-1] = {5'd7, e[2], 1'b1, e[0]};                      // R7
  endtask

  always @(posedge clk or negedge rst_n) begin : mdl
    bit rp0, rp1;
    if (!rst_n) begin
      since = 0;
      q0.delete();
      q1.delete();
    end else begin
      rp0 = (since >= LOCK) && (q0.size() == 0);
      rp1 = (since >= LOCK) && (q1.size() == 0);
      if (since < LOCK) since++;
      if (q0.size() > 0) void'(q0.pop_front());
      if (q1.size() > 0) void'(q1.pop_front());
      if (rp0 && start && plen != 0) begin          // R3, R8, R11
        build(1'b0, dest, plen, pdata);
        foreach (pk[k]) q0.push_back(pk[k]);
      end
      if (rp1 && start && plen != 0) begin
        build(1'b1, dest, plen, pdata);
        foreach (pk[k]) q1.push_back(pk[k]);
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin : cmp
    logic [7:0] e0, e1;
    bit er0, er1;
    if (rst_n === 1'b1 && !done) begin
      e0  = (q0.size() != 0) ? q0[0] : {5'd2, 3'b011};   // R2 idle
      e1  = (q1.size() != 0) ? q1[0] : {5'd2, 3'b011};
      er0 = (since >= LOCK) && (q0.size() == 0);
      er1 = (since >= LOCK) && (q1.size() == 0);
      chk({sd[0], sf[0], sv[0]} === e0[2:0], int'(e0[7:3]), "gapless wires",
          {61'd0, sd[0], sf[0], sv[0]}, {61'd0, e0[2:0]});
      chk({sd[1], sf[1], sv[1]} === e1[2:0], int'(e1[7:3]), "gapped wires",
          {61'd0, sd[1], sf[1], sv[1]}, {61'd0, e1[2:0]});
      chk(rdy[0] === er0, (since < LOCK) ? 1 : 3, "gapless ready",
          {63'd0, rdy[0]}, {63'd0, er0});
      chk(rdy[1] === er1, (since < LOCK) ? 1 : 3, "gapped ready",
          {63'd0, rdy[1]}, {63'd0, er1});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_both_ready();
    while (rdy !== 2'b11) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] a, input logic [3:0] n,
                      input logic [63:0] p, input int n_eff);
    int c0, c1;
    wait_both_ready();
    dest = a; plen = n; pdata = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble the sampled inputs while the packet is on the wire
    dest = ~a; plen = ~n; pdata = ~p;
    if (n == 0) begin
      chk(rdy === 2'b11, 8, "ready after zero-length start", {62'd0, rdy}, 64'd3); // R8
      chk(sf === 2'b11 && sv === 2'b11, 8, "wires idle after zero-length start",
          {60'd0, sf, sv}, 64'hF);
    end else begin
      c0 = 0; c1 = 0;
      while (rdy !== 2'b11) begin
        if (rdy[0] !== 1'b1) c0++;
        if (rdy[1] !== 1'b1) c1++;
        @(negedge clk);
      end
      chk(c0 == 9 + 8 * n_eff, (n > MAXB) ? 9 : 6, "gapless packet length",
          64'(c0), 64'(9 + 8 * n_eff));                          // R6, R9
      chk(c1 == 9 + 9 * n_eff - 1, 10, "gapped packet length",
          64'(c1), 64'(9 + 9 * n_eff - 1));                      // R10
    end
  endtask

  initial begin
    int j;
    rst_n = 1'b0; start = 1'b1; dest = 4'h9; plen = 4'd2;
    pdata = 64'h0123_4567_89AB_C35A;
    repeat (3) @(negedge clk);
    // R1, R2: reset state
    chk(rdy === 2'b00, 1, "ready in reset", {62'd0, rdy}, 64'd0);
    chk(sd === 2'b00 && sf === 2'b11 && sv === 2'b11, 2, "wires in reset",
        {58'd0, sd, sf, sv}, 64'h0F);
    rst_n = 1'b1;
    // R1: start held high; ready must first appear after edge 17
    j = 0;
    do begin @(negedge clk); j++; end while (rdy[0] !== 1'b1 && j < 40);
    chk(j == LOCK, 1, "first ready edge count", 64'(j), 64'(LOCK));
    @(negedge clk);
    start = 1'b0;
    chk(rdy === 2'b00, 3, "ready drops on acceptance", {62'd0, rdy}, 64'd0); // R3
    dest = 4'h6; pdata = ~pdata;                                             // R11
    wait_both_ready();

    send(4'hA, 4'd1, 64'h0000_0000_0000_00C6, 1);
    send(4'h5, 4'd3, 64'h0000_0000_00F0_0F81, 3);
    send(4'h3, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0);      // R8
    send(4'hF, 4'd8, 64'hDEAD_BEEF_5AA5_1248, 8);
    send(4'h0, 4'd15, 64'h8001_7E7E_0F0F_3C21, 8);     // R9
    send(4'h1, 4'd9, 64'h1122_3344_5566_7788, 8);      // R9

    // R3: start held high, back-to-back acceptance on the first ready cycle
    wait_both_ready();
    dest = 4'hC; plen = 4'd2; pdata = 64'h0000_0000_0000_A5E7; start = 1'b1;
    repeat (70) @(negedge clk);
    start = 1'b0;
    wait_both_ready();

    // R12: reset in the middle of a packet
    dest = 4'h7; plen = 4'd4; pdata = 64'h0000_0000_CAFE_F00D; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(sd === 2'b00 && sf === 2'b11 && sv === 2'b11, 12, "wires idle at reset",
        {58'd0, sd, sf, sv}, 64'h0F);
    chk(rdy === 2'b00, 12, "ready low at reset", {62'd0, rdy}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    j = 0;
    do begin @(negedge clk); j++; end while (rdy[0] !== 1'b1 && j < 40);
    chk(j == LOCK, 12, "quiet period restarts", 64'(j), 64'(LOCK));
    send(4'h2, 4'd2, 64'h0000_0000_0000_69B4, 2);
    repeat (4) @(negedge clk);
    finish_run();
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule